// File: doc/BRIEF.md
# One-Shot Seconds Interval Timer

This block is a host-programmed one-shot timer with whole-second resolution. The host writes an 8-bit count of seconds from 1 to 255. Timing begins on the clock edge that takes the write. A prescaler divides the system clock down to a one-second tick. When the programmed number of seconds has elapsed, the block sets a sticky expiry flag. The interrupt output follows that flag whenever the host has enabled interrupts.

Writing a count of zero stops the timer. The prescaler and the seconds counter are then held still, which saves power. After it expires, the timer stays idle until the host writes a new count. A write made while a count is running replaces the running count.

After reset, the flag reads as set and the timer is not yet usable. The host must clear the flag once to bring the timer into service.

The controller is a three-state machine:
- ST_UNINIT: after reset, before the first flag clear.
- ST_IDLE: disabled or expired, with the counters gated.
- ST_COUNT: timing is in progress.

Its transitions are:
- UNINIT to IDLE on a flag clear.
- IDLE to COUNT on a nonzero write.
- COUNT to COUNT on a nonzero write, which restarts the count.
- COUNT to IDLE on a zero write.
- COUNT to IDLE on expiry, when the last second's tick arrives.

Top module: `sot_oneshot_timer`

## Requirements
- R1: After reset, `timer_flag` reads 1, the timer is uninitialised and `irq` is 0 whatever the value of `irq_en`.
- R2: While uninitialised, writes are ignored. A pulse on `flag_clr` clears the flag and initialises the timer. A write taken in the same cycle as that first clear is also ignored.
- R3: A write of value V in the range 1..255 to an initialised timer sets `timer_flag` on the clock edge exactly V×CLK_PER_SEC cycles after the edge that took the write. The prescaler restarts on the write, so the first second is full length.
- R4: A write of 0 disables the timer. No expiry follows, and the prescaler and seconds counter are held at zero until the next nonzero write, which arms the timer normally.
- R5: A nonzero write while counting discards the running count and restarts timing from the new value, measured from the new write. A write landing on the expiry edge suppresses that expiry.
- R6: The timer is one-shot. After expiry it stays idle, and the flag does not set again until a new nonzero write has run its full time.
- R7: `timer_flag` stays set until `flag_clr` is pulsed. Writes do not change it. If expiry and `flag_clr` occur in the same cycle, the flag ends up set.
- R8: Once the timer is initialised, `irq` is 1 exactly when `timer_flag` and `irq_en` are both 1. `irq` is combinational from `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the seconds count |
| wr_data | input | 8 | Seconds to time; 0 disables the timer |
| flag_clr | input | 1 | Clears the expiry flag; the first clear after reset initialises the timer |
| irq_en | input | 1 | Interrupt enable |
| timer_flag | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several invariants on every cycle:
- Writes leave the machine in ST_UNINIT until it is initialised.
- The prescaler rests at zero in every state except ST_COUNT.
- The seconds counter is never zero while counting.
- The flag only rises out of ST_COUNT and holds until cleared.
- `irq` never appears without both the flag and the enable.

Only the bench scenarios can show the exact V×CLK_PER_SEC expiry latency, the restart on a rewrite, the silence after a zero write or after a one-shot expiry, and the set-over-clear priority. These require measuring time from a specific write.

// File: rtl/sot_pkg.sv
package sot_pkg;
    typedef enum logic [1:0] {
        ST_UNINIT = 2'd0,
        ST_IDLE   = 2'd1,
        ST_COUNT  = 2'd2
    } sot_state_e;
endpackage

// File: rtl/sot_prescaler.sv
module sot_prescaler #(
    parameter int CLK_PER_SEC = 50_000_000,
    localparam int PRE_W = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    output logic             tick,
    output logic [PRE_W-1:0] pre_cnt
);
    localparam logic [PRE_W-1:0] LAST = PRE_W'(CLK_PER_SEC - 1);

    logic [PRE_W-1:0] cnt_q;

    // A tick marks the end of one full second inside an active count
    assign tick    = run && !restart && (cnt_q == LAST);
    assign pre_cnt = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sot_fsm.sv
module sot_fsm
    import sot_pkg::*;
#(
    parameter int COUNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [COUNT_W-1:0] wr_data,
    input  logic               flag_clr,
    input  logic               tick,
    output sot_state_e         state,
    output logic [COUNT_W-1:0] secs_left,
    output logic               run,
    output logic               restart,
    output logic               expire,
    output logic               initialised
);
    sot_state_e         st_q, st_d;
    logic [COUNT_W-1:0] secs_q;
    logic               wr_ok;
    logic               last_sec;

    assign wr_ok    = wr_en && (st_q != ST_UNINIT);
    assign last_sec = (secs_q == COUNT_W'(1));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_UNINIT: if (flag_clr) st_d = ST_IDLE;
            ST_IDLE:   if (wr_en) st_d = (wr_data != '0) ? ST_COUNT : ST_IDLE;
            ST_COUNT: begin
                if (wr_en)                 st_d = (wr_data != '0) ? ST_COUNT : ST_IDLE;
                else if (tick && last_sec) st_d = ST_IDLE;
            end
            default:   st_d = ST_UNINIT;
        endcase
    end

    // State register and seconds counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_UNINIT;
            secs_q <= '0;
        end else begin
            st_q <= st_d;
            if (wr_ok)                       secs_q <= wr_data;
            else if (st_q == ST_COUNT && tick) secs_q <= secs_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        run         = (st_q == ST_COUNT);
        restart     = wr_ok;
        expire      = (st_q == ST_COUNT) && !wr_en && tick && last_sec;
        initialised = (st_q != ST_UNINIT);
    end

    assign state     = st_q;
    assign secs_left = secs_q;
endmodule

// File: rtl/sot_flag.sv
module sot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic flag_clr,
    input  logic irq_en,
    input  logic initialised,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // The flag powers up set; expiry takes priority over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b1;
        else if (expire)   flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en & initialised;
endmodule

// File: rtl/sot_oneshot_timer.sv
module sot_oneshot_timer
    import sot_pkg::*;
#(
    parameter int CLK_PER_SEC = 50_000_000,
    parameter int COUNT_W     = 8,
    localparam int PRE_W = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [COUNT_W-1:0] wr_data,
    input  logic               flag_clr,
    input  logic               irq_en,
    output logic               timer_flag,
    output logic               irq
);
    sot_state_e         st_q;
    logic [COUNT_W-1:0] secs_q;
    logic [PRE_W-1:0]   pre_cnt;
    logic               run, restart, tick, expire, initialised;

    sot_prescaler #(.CLK_PER_SEC(CLK_PER_SEC)) pre_i (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .tick(tick), .pre_cnt(pre_cnt)
    );

    sot_fsm #(.COUNT_W(COUNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .tick(tick), .state(st_q), .secs_left(secs_q),
        .run(run), .restart(restart), .expire(expire), .initialised(initialised)
    );

    sot_flag flag_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .flag_clr(flag_clr),
        .irq_en(irq_en), .initialised(initialised),
        .flag(timer_flag), .irq(irq)
    );
endmodule

// File: rtl/sot_checker.sv
module sot_checker
    import sot_pkg::*;
#(
    parameter int PRE_W   = 1,
    parameter int COUNT_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               flag_clr,
    input logic               irq_en,
    input logic               timer_flag,
    input logic               irq,
    input sot_state_e         state,
    input logic [COUNT_W-1:0] secs_left,
    input logic [PRE_W-1:0]   pre_cnt
);
    AST_UNINIT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNINIT) |-> !irq); // R1

    AST_UNINIT_IGNORES_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNINIT && wr_en && !flag_clr) |=> (state == ST_UNINIT)); // R2

    AST_SECS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (secs_left != '0)); // R3

    AST_PRESCALER_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_COUNT) |-> (pre_cnt == '0)); // R4

    AST_FLAG_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timer_flag) |-> ($past(state) == ST_COUNT)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_flag && !flag_clr) |=> timer_flag); // R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (timer_flag && irq_en)); // R8
endmodule

bind sot_oneshot_timer sot_checker #(.PRE_W(PRE_W), .COUNT_W(COUNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .flag_clr(flag_clr),
    .irq_en(irq_en), .timer_flag(timer_flag), .irq(irq),
    .state(st_q), .secs_left(secs_q), .pre_cnt(pre_cnt)
);

// File: tb/sot_oneshot_timer_tb_top.sv
module sot_oneshot_timer_tb_top;
    localparam int P = 10;
    localparam int NV = 6;
    localparam int VALS [NV] = '{1, 2, 3, 7, 16, 255};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       timer_flag, irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    sot_oneshot_timer #(.CLK_PER_SEC(P), .COUNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flag_clr(flag_clr), .irq_en(irq_en), .timer_flag(timer_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; the write is taken on the next rising edge
    task automatic wr(input int v);
        wr_en = 1'b1;
        wr_data = 8'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        irq_en = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 flag after reset", timer_flag, 1'b1);
        chk("R1 irq masked before init", irq, 1'b0);

        // R2: a write before initialisation must not start timing
        wr(3);
        idle(P);
        chk("R1 irq still masked", irq, 1'b0);
        clr();
        chk("R2 clear initialises", timer_flag, 1'b0);
        idle(3 * P);
        chk("R2 early write ignored", timer_flag, 1'b0);

        // R3: table of counts with exact expiry timing
        for (int i = 0; i < NV; i++) begin
            wr(VALS[i]);
            idle(VALS[i] * P - 1);
            chk("R3 not yet expired", timer_flag, 1'b0);
            idle(1);
            chk("R3 expired on time", timer_flag, 1'b1);
            chk("R8 irq with flag and enable", irq, 1'b1);
            clr();
            chk("R7 clear drops flag", timer_flag, 1'b0);
        end

        // R7: flag sticky, writes leave it alone
        wr(1);
        idle(P + 20);
        chk("R7 flag sticky", timer_flag, 1'b1);
        wr(2);
        chk("R7 write keeps flag", timer_flag, 1'b1);
        idle(2 * P + 2);
        clr();
        chk("R7 cleared", timer_flag, 1'b0);

        // R6: one-shot, no re-fire
        idle(5 * P);
        chk("R6 no repeat expiry", timer_flag, 1'b0);

        // R8: enable gating of the interrupt
        irq_en = 1'b0;
        wr(1);
        idle(P);
        chk("R8 flag set", timer_flag, 1'b1);
        chk("R8 irq off when disabled", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk("R8 irq follows enable", irq, 1'b1);
        idle(1);
        clr();

        // R4: zero write disables, then a new write arms normally
        wr(5);
        idle(2 * P);
        wr(0);
        idle(10 * P);
        chk("R4 disabled no expiry", timer_flag, 1'b0);
        wr(1);
        idle(P - 1);
        chk("R4 rearm not early", timer_flag, 1'b0);
        idle(1);
        chk("R4 rearm expires", timer_flag, 1'b1);
        clr();

        // R5: rewrite during a count restarts from the new write
        wr(4);
        idle(2 * P + 3);
        wr(2);
        idle(2 * P - 1);
        chk("R5 restart not early", timer_flag, 1'b0);
        idle(1);
        chk("R5 restart expires", timer_flag, 1'b1);
        clr();

        // R7: expiry and clear in the same cycle leaves the flag set
        wr(1);
        idle(P - 1);
        flag_clr = 1'b1;
        idle(1);
        flag_clr = 1'b0;
        chk("R7 set beats clear", timer_flag, 1'b1);
        clr();
        chk("R7 final clear", timer_flag, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule